// File: doc/BRIEF.md
# T1 Transmit Payload Override Unit

This block sits in the serial transmit path of a T1 formatter, where a frame is one framing bit followed by 24 channels of 8 bits, 193 bits in all. It takes NRZ serial data one bit per bit-clock strobe. It also takes a strobe that marks the framing-bit position, the framing-bit value to send there, and a flag that marks frame 12 of the superframe. It returns the same stream with payload bits replaced or modified according to a set of static control inputs.

The overrides are:
- an unframed all-ones alarm;
- repeating loop-activate (`00001`) and loop-release (`001`) code patterns;
- a yellow alarm that can take either of two forms;
- zero-byte suppression, which forces the seventh bit of an all-zero channel byte to one, either in every channel or in channels picked by a 24-bit mask.

When several overrides are active, they are applied in a fixed order of precedence. The framing bit stays in its position under the loop codes. Because zero detection needs a whole channel byte, the stream is delayed by one channel (8 bit periods). Asking for both loop codes at once is flagged as an illegal setting.

Top module: `tx_payload_override`

## Requirements
- R1: `ser_out` reproduces the bit presented with the bit strobe 8 strobes earlier, when no override applies. `ser_out` only changes on a cycle where `bit_en` is high.
- R2: After reset, `ser_out` is 1 until the first input bit has crossed the 8-strobe delay. During that time, output strobes do not advance the loop-code pattern.
- R3: At a framing position (`fbit_in` high with the strobe), the value sent is `fval_in` and `ser_in` is ignored. Payload bits are numbered 1..8 in order of transmission. The first payload bit after the framing bit is bit 1 of channel 0.
- R4: With `blue_en` set, every output bit is 1, including framing positions. This holds regardless of every other control.
- R5: With `loopup_en` set, payload bits carry the repeating pattern 0,0,0,0,1. The pattern phase starts at the first 0 after reset or enable, and it does not advance on framing positions.
- R6: With `loopdn_en` set (and `loopup_en` clear), payload bits carry the repeating pattern 0,0,1 under the same phase rules as R5.
- R7: While a loop code is sent, framing positions still carry the framing value. This includes the frame-12 forcing of R10.
- R8: `cfg_err` is 1 in the cycle after a cycle in which `loopup_en` and `loopdn_en` are both high, and 0 otherwise. In that state, the loop-activate pattern is sent.
- R9: With `yellow_en` set and `yellow_sel` = 0, payload bit 2 of every channel is sent as 0.
- R10: With `yellow_en` set and `yellow_sel` = 1, the framing position of a frame marked by `frame12_in` is sent as 1.
- R11: With `stuff_all` set, an all-zero channel byte is sent with its bit 7 set to 1. Bytes with any one bit are sent unchanged.
- R12: With `stuff_all` clear, zero-byte suppression applies to channel c only when `stuff_mask[c]` is 1.
- R13: Precedence from highest to lowest is: all-ones alarm, loop code, yellow alarm, zero-byte suppression, raw data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe, one per transmitted bit |
| ser_in | input | 1 | Serial NRZ payload input |
| fbit_in | input | 1 | Marks the framing-bit position |
| fval_in | input | 1 | Framing-bit value for that position |
| frame12_in | input | 1 | High during frame 12 of the superframe |
| stuff_all | input | 1 | Zero-byte suppression in every channel |
| stuff_mask | input | 24 | Per-channel zero-byte suppression enables |
| blue_en | input | 1 | Unframed all-ones alarm |
| yellow_en | input | 1 | Yellow alarm enable |
| yellow_sel | input | 1 | 0: bit 2 zeroed, 1: frame-12 framing bit set |
| loopup_en | input | 1 | Send loop-activate pattern |
| loopdn_en | input | 1 | Send loop-release pattern |
| ser_out | output | 1 | Modified serial stream |
| cfg_err | output | 1 | Both loop codes requested |

## Verification
The bench sweeps the control settings over thirteen frames each, with a mix of zero and non-zero channel bytes. It recomputes every output bit from frame position, channel number and a payload-bit count of its own. Each corner case has a characteristic failure:
- If the zero-detect flag is latched one byte off, suppression lands on a neighbour channel.
- If the loop-code phase advances on framing bits, the pattern slips by one bit every frame.
- If framing positions are not kept under a loop code, a framing bit turns into pattern.
- If the blue alarm is ranked below the loop codes, zeros leak out.
- If the pipeline is not marked as filled, reset garbage shows up and the loop phase is shifted.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

  // One slot of the channel-delay line
  typedef struct packed {
    logic valid;  // slot holds a real input bit
    logic fbit;   // framing position
    logic f12;    // belongs to frame 12
    logic ybit;   // payload bit 2 of a channel
    logic sbit;   // payload bit 7 of a channel
    logic data;   // bit value (framing value at framing positions)
  } tpo_slot_t;

  typedef struct packed {
    logic blue;
    logic lu;
    logic ld;
    logic yel;
    logic ysel;
  } tpo_ctrl_t;

  // Output bit of a repeating code: a one on the last phase only
  function automatic logic tpo_code_bit(int phase, int len);
    return (phase == len - 1);
  endfunction

  // Next phase of a repeating code
  function automatic int tpo_code_next(int phase, int len);
    return (phase >= len - 1) ? 0 : phase + 1;
  endfunction

  // Precedence: blue > loop code > yellow > zero-byte suppression > data
  function automatic logic tpo_pick(tpo_slot_t s, tpo_ctrl_t c, logic stuff_hit,
                                    logic lu_b, logic ld_b);
    logic r;
    if (!s.valid || c.blue)            r = 1'b1;
    else if (s.fbit)                   r = (c.yel && c.ysel && s.f12) ? 1'b1 : s.data;
    else if (c.lu)                     r = lu_b;
    else if (c.ld)                     r = ld_b;
    else if (c.yel && !c.ysel && s.ybit) r = 1'b0;
    else if (stuff_hit && s.sbit)      r = 1'b1;
    else                               r = s.data;
    return r;
  endfunction

endpackage

// File: rtl/tpo_align.sv
module tpo_align
  import tpo_pkg::*;
#(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  parameter int STUFF_POS   = 7,
  parameter int YEL_POS     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                ser_in,
  input  logic                fbit_in,
  input  logic                fval_in,
  input  logic                frame12_in,
  input  logic                stuff_all,
  input  logic [CHANNELS-1:0] stuff_mask,
  output tpo_slot_t           head,
  output logic                stuff_hit
);
  localparam int BIT_W = $clog2(BITS_PER_CH);
  localparam int CH_W  = $clog2(CHANNELS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CHANNELS - 1);

  logic [BIT_W-1:0]       bitpos;
  logic [CH_W-1:0]        chan;
  logic [BITS_PER_CH-2:0] byte_q;
  tpo_slot_t              dl [BITS_PER_CH];
  tpo_slot_t              slot_in;
  logic                   byte_done;
  logic [BITS_PER_CH-1:0] full_byte;

  assign byte_done = bit_en && !fbit_in && (bitpos == LAST_BIT);
  assign full_byte = {byte_q, ser_in};

  always_comb begin
    slot_in.valid = 1'b1;
    slot_in.fbit  = fbit_in;
    slot_in.f12   = frame12_in;
    slot_in.ybit  = !fbit_in && (bitpos == BIT_W'(YEL_POS - 1));
    slot_in.sbit  = !fbit_in && (bitpos == BIT_W'(STUFF_POS - 1));
    slot_in.data  = fbit_in ? fval_in : ser_in;
  end

  // Input-side frame position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitpos <= '0;
      chan   <= '0;
      byte_q <= '0;
    end else if (bit_en) begin
      if (fbit_in) begin
        bitpos <= '0;
        chan   <= '0;
      end else begin
        byte_q <= {byte_q[BITS_PER_CH-3:0], ser_in};
        if (bitpos == LAST_BIT) begin
          bitpos <= '0;
          chan   <= (chan == LAST_CH) ? '0 : chan + 1'b1;
        end else begin
          bitpos <= bitpos + 1'b1;
        end
      end
    end
  end

  // Zero-byte flag for the channel now leaving the delay line
  always_ff @(posedge clk) begin
    if (!rst_n)         stuff_hit <= 1'b0;
    else if (byte_done) stuff_hit <= (full_byte == '0) && (stuff_all || stuff_mask[chan]);
  end

  // One-channel delay line
  generate
    for (genvar i = 0; i < BITS_PER_CH; i++) begin : g_dl
      always_ff @(posedge clk) begin
        if (!rst_n)      dl[i] <= '0;
        else if (bit_en) dl[i] <= (i == 0) ? slot_in : dl[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign head = dl[BITS_PER_CH-1];

  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fbit_in) |=> (bitpos == '0 && chan == '0)); // R3

  AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(head)); // R1
endmodule

// File: rtl/tpo_codegen.sv
module tpo_codegen
  import tpo_pkg::*;
#(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  output logic code_bit
);
  localparam int PH_W = $clog2(LEN);

  logic [PH_W-1:0] phase;

  assign code_bit = tpo_code_bit(int'(phase), LEN);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) phase <= '0;
    else if (step)         phase <= PH_W'(tpo_code_next(int'(phase), LEN));
  end

  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == '0)); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step) |=> $stable(phase)); // R5
endmodule

// File: rtl/tpo_outmux.sv
module tpo_outmux
  import tpo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  tpo_slot_t head,
  input  logic      stuff_hit,
  input  tpo_ctrl_t ctrl,
  input  logic      lu_bit,
  input  logic      ld_bit,
  output logic      ser_out,
  output logic      cfg_err
);
  logic pick;

  assign pick = tpo_pick(head, ctrl, stuff_hit, lu_bit, ld_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_out <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= ctrl.lu && ctrl.ld;
      if (bit_en) ser_out <= pick;
    end
  end

  AST_BLUE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ctrl.blue) |=> ser_out); // R4

  AST_CFG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.lu && ctrl.ld) |=> cfg_err); // R8

  AST_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && head.valid && head.fbit && !ctrl.blue && !(ctrl.yel && ctrl.ysel))
      |=> (ser_out == $past(head.data))); // R7

  AST_PREFILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !head.valid) |=> ser_out); // R2
endmodule

// File: rtl/tx_payload_override.sv
module tx_payload_override
  import tpo_pkg::*;
#(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  parameter int STUFF_POS   = 7,
  parameter int YEL_POS     = 2,
  parameter int LU_LEN      = 5,
  parameter int LD_LEN      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                ser_in,
  input  logic                fbit_in,
  input  logic                fval_in,
  input  logic                frame12_in,
  input  logic                stuff_all,
  input  logic [CHANNELS-1:0] stuff_mask,
  input  logic                blue_en,
  input  logic                yellow_en,
  input  logic                yellow_sel,
  input  logic                loopup_en,
  input  logic                loopdn_en,
  output logic                ser_out,
  output logic                cfg_err
);
  tpo_slot_t head;
  tpo_ctrl_t ctrl;
  logic      stuff_hit;
  logic      code_step;
  logic      lu_bit;
  logic      ld_bit;

  assign ctrl = '{blue: blue_en, lu: loopup_en, ld: loopdn_en,
                  yel: yellow_en, ysel: yellow_sel};

  // Codes advance only on real payload bits leaving the delay line
  assign code_step = bit_en && head.valid && !head.fbit;

  tpo_align #(
    .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH),
    .STUFF_POS(STUFF_POS), .YEL_POS(YEL_POS)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .fbit_in(fbit_in), .fval_in(fval_in), .frame12_in(frame12_in),
    .stuff_all(stuff_all), .stuff_mask(stuff_mask),
    .head(head), .stuff_hit(stuff_hit)
  );

  tpo_codegen #(.LEN(LU_LEN)) u_lu (
    .clk(clk), .rst_n(rst_n), .enable(loopup_en), .step(code_step), .code_bit(lu_bit)
  );

  tpo_codegen #(.LEN(LD_LEN)) u_ld (
    .clk(clk), .rst_n(rst_n), .enable(loopdn_en), .step(code_step), .code_bit(ld_bit)
  );

  tpo_outmux u_mux (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .head(head), .stuff_hit(stuff_hit),
    .ctrl(ctrl), .lu_bit(lu_bit), .ld_bit(ld_bit), .ser_out(ser_out), .cfg_err(cfg_err)
  );
endmodule

// File: tb/tx_payload_override_tb.sv
module tx_payload_override_tb;
  localparam int FRAMES = 13;
  localparam int FLEN   = 193;
  localparam int NT     = FRAMES * FLEN;
  localparam int LAT    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        ser_in = 1'b0, fbit_in = 1'b0, fval_in = 1'b0, frame12_in = 1'b0;
  logic        stuff_all = 1'b0;
  logic [23:0] stuff_mask = '0;
  logic        blue_en = 1'b0, yellow_en = 1'b0, yellow_sel = 1'b0;
  logic        loopup_en = 1'b0, loopdn_en = 1'b0;
  logic        ser_out, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  logic s_data [NT];
  logic s_f    [NT];
  logic s_f12  [NT];
  int   s_bit  [NT];
  logic s_zero [NT];
  int   s_ch   [NT];

  always #4 clk = ~clk;

  tx_payload_override u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .fbit_in(fbit_in),
    .fval_in(fval_in), .frame12_in(frame12_in), .stuff_all(stuff_all),
    .stuff_mask(stuff_mask), .blue_en(blue_en), .yellow_en(yellow_en),
    .yellow_sel(yellow_sel), .loopup_en(loopup_en), .loopdn_en(loopdn_en),
    .ser_out(ser_out), .cfg_err(cfg_err)
  );

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int byte_val(int fr, int ch, int seed);
    if (((fr * 7 + ch * 13 + seed) % 4) == 0) return 0;
    return ((fr * 37 + ch * 11 + seed * 5) % 255) + 1;
  endfunction

  // Build the input stream: slot 0 of a frame is the framing position
  task automatic build(int seed);
    for (int k = 0; k < NT; k++) begin
      int fr = k / FLEN;
      int pos = k % FLEN;
      s_f12[k] = ((fr % 12) == 11);
      if (pos == 0) begin
        s_f[k] = 1'b1; s_data[k] = 1'(((fr * 5 + seed) % 3) == 0);
        s_bit[k] = 0; s_ch[k] = 0; s_zero[k] = 1'b0;
      end else begin
        int ch = (pos - 1) / 8;
        int b  = (pos - 1) % 8;
        int v  = byte_val(fr, ch, seed);
        s_f[k] = 1'b0; s_ch[k] = ch; s_bit[k] = b + 1;
        s_data[k] = 1'((v >> (7 - b)) & 1);
        s_zero[k] = (v == 0);
      end
    end
  endtask

  task automatic scenario(string req, int seed, logic bl, logic ye, logic ys, logic lu,
                          logic ld, logic sa, logic [23:0] sm);
    int   bad = 0;
    int   pre_bad = 0;
    int   pay = 0;
    int   first_act = 0, first_exp = 0;
    logic last;
    build(seed);
    @(negedge clk); rst_n = 1'b0; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    blue_en = bl; yellow_en = ye; yellow_sel = ys; loopup_en = lu; loopdn_en = ld;
    stuff_all = sa; stuff_mask = sm;
    check("R2", int'(ser_out), 1, {req, " reset value of ser_out"});
    check("R8", int'(cfg_err), 0, {req, " reset value of cfg_err"});
    last = ser_out;
    for (int k = 0; k < NT + LAT; k++) begin
      logic e;
      // R1: output holds between strobes
      if (ser_out !== last) begin bad++; if (bad == 1) begin first_act = int'(ser_out); first_exp = int'(last); end end
      bit_en = 1'b1;
      if (k < NT) begin
        fbit_in = s_f[k]; frame12_in = s_f12[k];
        ser_in  = s_f[k] ? ~s_data[k] : s_data[k];  // R3: ser_in ignored at framing slot
        fval_in = s_f[k] ? s_data[k] : ~s_data[k];
      end else begin
        fbit_in = 1'b0; frame12_in = 1'b0; ser_in = 1'b0; fval_in = 1'b0;
      end
      @(negedge clk);
      bit_en = 1'b0;
      if (k < LAT) begin
        e = 1'b1;
        if (ser_out !== e) pre_bad++;
      end else begin
        int j = k - LAT;
        if (bl) e = 1'b1;
        else if (s_f[j]) e = (ye && ys && s_f12[j]) ? 1'b1 : s_data[j];
        else if (lu) e = ((pay % 5) == 4);
        else if (ld) e = ((pay % 3) == 2);
        else if (ye && !ys && s_bit[j] == 2) e = 1'b0;
        else if (s_zero[j] && (sa || sm[s_ch[j]]) && s_bit[j] == 7) e = 1'b1;
        else e = s_data[j];
        if (!s_f[j]) pay++;
        if (ser_out !== e) begin
          bad++;
          if (bad == 1) begin first_act = int'(ser_out); first_exp = int'(e); end
        end
      end
      last = ser_out;
      @(negedge clk);
    end
    check("R2", pre_bad, 0, {req, " prefill bits not one"});
    if (bad != 0) $display("  first mismatch in %s: actual %0d expected %0d", req, first_act, first_exp);
    check(req, bad, 0, {req, " stream mismatches"});
    check("R8", int'(cfg_err), int'(lu && ld), {req, " cfg_err with controls applied"});
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    scenario("R1", 1, 0, 0, 0, 0, 0, 0, 24'h0);          // raw pass, R3 framing value
    scenario("R3", 2, 0, 0, 0, 0, 0, 0, 24'h0);
    scenario("R11", 3, 0, 0, 0, 0, 0, 1, 24'h0);
    scenario("R12", 4, 0, 0, 0, 0, 0, 0, 24'hA53C0F);
    scenario("R9", 5, 0, 1, 0, 0, 0, 0, 24'h0);
    scenario("R10", 6, 0, 1, 1, 0, 0, 0, 24'h0);
    scenario("R4", 7, 1, 1, 1, 1, 0, 1, 24'hFFFFFF);      // blue over everything
    scenario("R5", 8, 0, 0, 0, 1, 0, 0, 24'h0);
    scenario("R6", 9, 0, 0, 0, 0, 1, 0, 24'h0);
    scenario("R7", 10, 0, 1, 1, 0, 1, 1, 24'h0);         // loop keeps framing, frame 12 forced
    scenario("R8", 11, 0, 0, 0, 1, 1, 0, 24'h0);         // illegal: loop-up sent
    scenario("R13", 12, 0, 1, 0, 0, 0, 1, 24'h0F0F0F);   // yellow over suppression
    scenario("R13", 13, 0, 1, 0, 1, 0, 1, 24'h0);        // loop over yellow and suppression
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule